// File: doc/BRIEF.md
# Remap and Pause Register Controller

This block is a small word-wide register target used during boot. Software reaches it through a simple synchronous register port. From there it can read a fixed identification word and park the processor with a halt output that releases when an interrupt arrives. It can also keep or clear a sticky flag that records a power-on reset, and it can fire a one-cycle command that tells the address-translation logic to leave the boot-time memory map for the normal map.

Every write effect depends only on the offset written, never on the data, so the port carries no write-data lines. Read data is combinational and is returned in the same cycle as the read strobe. Address translation, arbitration and the processor live outside the block.

Top module: `rpc_remap_pause`

## Requirements
- R1: While `rst_n` is low, at the next clock edge the status flag becomes 1, `halt_o` becomes 0 and `boot_map_clr_o` becomes 0. After release, a read at offset 0x30 returns 1.
- R2: A write to offset 0x00 in a cycle where `irq_i` is low sets `halt_o` high from the following clock edge.
- R3: Once high, `halt_o` stays high while `irq_i` is low. It falls at the first clock edge that samples `irq_i` high. A write to 0x00 in a cycle where `irq_i` is high is ignored.
- R4: A read at offset 0x10 returns the parameter `ID_WORD` (default 32'h7D15_0C3A) in the same cycle.
- R5: A write to offset 0x20 makes `boot_map_clr_o` high for exactly the one cycle after the write cycle. With no further write there, it returns to 0.
- R6: A read at offset 0x30 returns the status flag in bit 0, and all other bits are 0.
- R7: A write to offset 0x30 sets the status flag to 1. A write to offset 0x34 clears it to 0.
- R8: Reads of reserved offsets (0x00, 0x20, 0x34), of unmapped offsets (0x04 to 0x0C, 0x14 to 0x1C, 0x24 to 0x2C, 0x38 to 0x3C) and of any offset whose low two bits are not 00 return 0. Writes to 0x10, to unmapped offsets or to non-word-aligned offsets leave `halt_o`, `boot_map_clr_o` and the status flag unchanged.
- R9: While `reg_re` is low, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also marks a power-on reset in the status flag |
| reg_re | input | 1 | Read strobe for the register port |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (6) | Byte offset within the register window |
| reg_rdata | output | DW (32) | Read data, valid in the strobe cycle |
| irq_i | input | 1 | Interrupt request that releases the halt |
| halt_o | output | 1 | Holds the processor stopped while high |
| boot_map_clr_o | output | 1 | One-cycle command to leave the boot-time map |

## Verification
The hardest case to reach is the collision between a pause write and the interrupt in the same cycle. Here the interrupt must win, and the halt must not latch after the interrupt has gone. The stimulus table first drives a pause write with the interrupt low, then drops the halt with an interrupt. It then repeats the pause write with the interrupt held high and checks that the halt stays low. Directed tests then show that the halt persists over many quiet cycles, and that a reset applied in the middle of a run restores the status flag that software had cleared.

// File: rtl/rpc_pkg.sv
// Package: shared decode types and register offsets for the remap/pause
// controller. Assumes byte offsets with word-aligned registers.
package rpc_pkg;

    // Register slots in the window; order is only an index, not an address.
    typedef enum logic [2:0] {
        SLOT_PAUSE  = 3'd0,
        SLOT_IDENT  = 3'd1,
        SLOT_LEAVE  = 3'd2,
        SLOT_STSET  = 3'd3,
        SLOT_STCLR  = 3'd4
    } slot_e;

    localparam int NSLOT = 5;

    // Byte offset of each slot; software depends on these values.
    function automatic logic [7:0] slot_offset(input int idx);
        case (idx)
            0:       slot_offset = 8'h00;
            1:       slot_offset = 8'h10;
            2:       slot_offset = 8'h20;
            3:       slot_offset = 8'h30;
            default: slot_offset = 8'h34;
        endcase
    endfunction

    // Write commands after decode.
    typedef struct packed {
        logic pause;
        logic leave;
        logic st_set;
        logic st_clr;
    } wr_cmd_t;

    // Read selects after decode.
    typedef struct packed {
        logic ident;
        logic status;
    } rd_sel_t;

endpackage

// File: rtl/rpc_decode.sv
// Module: rpc_decode
// Turns a register-port access into one-hot write commands and read selects.
// Assumes AW >= 6 and that only exact word-aligned offsets match a slot, so
// misaligned or unmapped offsets select nothing.
module rpc_decode
    import rpc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output wr_cmd_t       wr_cmd,
    output rd_sel_t       rd_sel
);

    logic [NSLOT-1:0] hit;

    // One comparator per slot, generated from the offset table.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [7:0] OFS = slot_offset(i);
        assign hit[i] = (addr == AW'(OFS));
    end

    // Qualify slot hits with the strobes; reserved directions map to nothing.
    always_comb begin
        wr_cmd.pause  = we && hit[SLOT_PAUSE];
        wr_cmd.leave  = we && hit[SLOT_LEAVE];
        wr_cmd.st_set = we && hit[SLOT_STSET];
        wr_cmd.st_clr = we && hit[SLOT_STCLR];
        rd_sel.ident  = re && hit[SLOT_IDENT];
        rd_sel.status = re && hit[SLOT_STSET];
    end

endmodule

// File: rtl/rpc_halt_ctrl.sv
// Module: rpc_halt_ctrl
// Holds the halt request from a pause command until an interrupt is seen.
// Assumes irq is synchronous to clk; the interrupt overrides a pause in the
// same cycle.
module rpc_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pause,
    input  logic irq,
    output logic halt
);

    // Set on pause, cleared by interrupt (interrupt has priority).
    always_ff @(posedge clk) begin
        if (!rst_n)     halt <= 1'b0;
        else if (irq)   halt <= 1'b0;
        else if (pause) halt <= 1'b1;
    end

endmodule

// File: rtl/rpc_status_flag.sv
// Module: rpc_status_flag
// Sticky power-on-reset flag. Reset forces it to 1; software sets or clears
// it. Assumes set and clear never arrive together (distinct offsets).
module rpc_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Reset marks a power-on; afterwards software owns the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b1;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/rpc_remap_pause.sv
// Module: rpc_remap_pause (top)
// Boot-control register target: identification word, halt-until-interrupt,
// sticky reset-status flag and a one-shot leave-boot-map command.
// Assumes a synchronous register port with combinational read data; writes
// carry no data because every effect depends on the offset alone.
module rpc_remap_pause
    import rpc_pkg::*;
#(
    parameter int          AW      = 6,
    parameter int          DW      = 32,
    parameter logic [DW-1:0] ID_WORD = DW'(32'h7D15_0C3A)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_re,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_rdata,
    input  logic          irq_i,
    output logic          halt_o,
    output logic          boot_map_clr_o
);

    wr_cmd_t wr_cmd;
    rd_sel_t rd_sel;
    logic    status_q;
    logic    leave_q;

    rpc_decode #(.AW(AW)) u_decode (
        .re     (reg_re),
        .we     (reg_we),
        .addr   (reg_addr),
        .wr_cmd (wr_cmd),
        .rd_sel (rd_sel)
    );

    rpc_halt_ctrl u_halt (
        .clk   (clk),
        .rst_n (rst_n),
        .pause (wr_cmd.pause),
        .irq   (irq_i),
        .halt  (halt_o)
    );

    rpc_status_flag u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wr_cmd.st_set),
        .clr   (wr_cmd.st_clr),
        .flag  (status_q)
    );

    // Register the leave command so it appears as a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) leave_q <= 1'b0;
        else        leave_q <= wr_cmd.leave;
    end

    assign boot_map_clr_o = leave_q;

    // Read mux: selected register or zero for reserved, unmapped, idle.
    always_comb begin
        reg_rdata = '0;
        if (rd_sel.ident)  reg_rdata = ID_WORD;
        if (rd_sel.status) reg_rdata = DW'(status_q);
    end

endmodule

// File: rtl/rpc_remap_pause_chk.sv
// Module: rpc_remap_pause_chk
// Protocol checker bound into rpc_remap_pause; observes ports and the
// status flag register.
module rpc_remap_pause_chk #(
    parameter int            AW      = 6,
    parameter int            DW      = 32,
    parameter logic [DW-1:0] ID_WORD = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_re,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic          irq_i,
    input logic          halt_o,
    input logic          boot_map_clr_o,
    input logic          status_q
);

    localparam logic [AW-1:0] A_PAUSE = AW'(8'h00);
    localparam logic [AW-1:0] A_IDENT = AW'(8'h10);
    localparam logic [AW-1:0] A_LEAVE = AW'(8'h20);
    localparam logic [AW-1:0] A_STSET = AW'(8'h30);
    localparam logic [AW-1:0] A_STCLR = AW'(8'h34);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status_q && !halt_o && !boot_map_clr_o));

    assert_pause_sets_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PAUSE && !irq_i) |=> halt_o);

    assert_irq_drops_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> !halt_o);

    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !irq_i) |=> halt_o);

    assert_halt_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(reg_we && reg_addr == A_PAUSE));

    assert_ident_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == A_IDENT) |-> reg_rdata == ID_WORD);

    assert_leave_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_LEAVE) |=> boot_map_clr_o);

    assert_leave_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_map_clr_o |-> $past(reg_we && reg_addr == A_LEAVE));

    assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == A_STSET) |-> reg_rdata == DW'(status_q));

    assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STSET) |=> status_q);

    assert_status_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STCLR) |=> !status_q);

    assert_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == A_STSET || reg_addr == A_STCLR)) |=> $stable(status_q));

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |-> reg_rdata == '0);

endmodule

bind rpc_remap_pause rpc_remap_pause_chk #(
    .AW      (AW),
    .DW      (DW),
    .ID_WORD (ID_WORD)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_re         (reg_re),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_rdata      (reg_rdata),
    .irq_i          (irq_i),
    .halt_o         (halt_o),
    .boot_map_clr_o (boot_map_clr_o),
    .status_q       (status_q)
);

// File: tb/tb_rpc_remap_pause.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module tb_rpc_remap_pause;

    localparam logic [31:0] ID = 32'h7D15_0C3A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_re = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_rdata;
    logic        irq_i = 1'b0;
    logic        halt_o;
    logic        boot_map_clr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rpc_remap_pause dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_re         (reg_re),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_rdata      (reg_rdata),
        .irq_i          (irq_i),
        .halt_o         (halt_o),
        .boot_map_clr_o (boot_map_clr_o)
    );

    typedef struct packed {
        logic        re;
        logic        we;
        logic        irq;
        logic [5:0]  addr;
        logic [31:0] exp_rd;   // expected read data in the access cycle
        logic        exp_halt; // expected halt after the edge
        logic        exp_clr;  // expected pulse after the edge
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 6'h30, 32'h1, 1'b0, 1'b0, 4'd1}, // R1 status after reset
        '{1'b1, 1'b0, 1'b0, 6'h10, ID,    1'b0, 1'b0, 4'd4}, // R4 ident
        '{1'b1, 1'b0, 1'b0, 6'h00, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 reserved read
        '{1'b0, 1'b1, 1'b0, 6'h34, 32'h0, 1'b0, 1'b0, 4'd7}, // R7 clear
        '{1'b1, 1'b0, 1'b0, 6'h30, 32'h0, 1'b0, 1'b0, 4'd6}, // R6 reads cleared
        '{1'b0, 1'b1, 1'b0, 6'h30, 32'h0, 1'b0, 1'b0, 4'd7}, // R7 set
        '{1'b1, 1'b0, 1'b0, 6'h30, 32'h1, 1'b0, 1'b0, 4'd6}, // R6 reads set
        '{1'b0, 1'b1, 1'b0, 6'h20, 32'h0, 1'b0, 1'b1, 4'd5}, // R5 leave pulse
        '{1'b0, 1'b0, 1'b0, 6'h10, 32'h0, 1'b0, 1'b0, 4'd9}, // R9 idle read, pulse gone
        '{1'b0, 1'b1, 1'b0, 6'h00, 32'h0, 1'b1, 1'b0, 4'd2}, // R2 pause
        '{1'b1, 1'b0, 1'b0, 6'h20, 32'h0, 1'b1, 1'b0, 4'd3}, // R3 holds, reserved read
        '{1'b0, 1'b1, 1'b0, 6'h10, 32'h0, 1'b1, 1'b0, 4'd8}, // R8 ident write ignored
        '{1'b0, 1'b0, 1'b1, 6'h00, 32'h0, 1'b0, 1'b0, 4'd3}, // R3 irq releases
        '{1'b0, 1'b1, 1'b1, 6'h00, 32'h0, 1'b0, 1'b0, 4'd3}, // R3 pause with irq ignored
        '{1'b1, 1'b0, 1'b0, 6'h38, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 unmapped read
        '{1'b1, 1'b0, 1'b0, 6'h31, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 misaligned read
        '{1'b0, 1'b1, 1'b0, 6'h36, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 misaligned write near clear
        '{1'b1, 1'b0, 1'b0, 6'h30, 32'h1, 1'b0, 1'b0, 4'd8}, // R8 flag unchanged
        '{1'b0, 1'b1, 1'b0, 6'h24, 32'h0, 1'b0, 1'b0, 4'd8}  // R8 unmapped write, no pulse
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: drive at negedge, check read data, then outputs after edge.
    task automatic access(input logic re, input logic we, input logic irq,
                          input logic [5:0] addr);
        @(negedge clk);
        reg_re = re; reg_we = we; irq_i = irq; reg_addr = addr;
        #1;
    endtask

    task automatic idle();
        access(1'b0, 1'b0, 1'b0, 6'h00);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        string tag;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "halt in reset", {31'b0, halt_o}, 32'h0);
        check("R1", "pulse in reset", {31'b0, boot_map_clr_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d", VECS[i].req);
            access(VECS[i].re, VECS[i].we, VECS[i].irq, VECS[i].addr);
            check(tag, $sformatf("vec%0d rdata", i), reg_rdata, VECS[i].exp_rd);
            @(posedge clk); #1;
            check(tag, $sformatf("vec%0d halt", i), {31'b0, halt_o}, {31'b0, VECS[i].exp_halt});
            check(tag, $sformatf("vec%0d pulse", i), {31'b0, boot_map_clr_o}, {31'b0, VECS[i].exp_clr});
        end

        // R3: halt persists across many quiet cycles with irq low
        access(1'b0, 1'b1, 1'b0, 6'h00);
        @(posedge clk); #1;
        access(1'b0, 1'b0, 1'b0, 6'h00);
        repeat (20) @(posedge clk);
        #1;
        check("R3", "halt held over quiet cycles", {31'b0, halt_o}, 32'h1);

        // R5: pulse lasts one cycle only
        access(1'b0, 1'b1, 1'b0, 6'h20);
        @(posedge clk); #1;
        check("R5", "pulse high", {31'b0, boot_map_clr_o}, 32'h1);
        idle();
        check("R5", "pulse low after one cycle", {31'b0, boot_map_clr_o}, 32'h0);

        // R1: mid-run reset restores the cleared flag and drops halt
        access(1'b0, 1'b1, 1'b0, 6'h34);
        @(posedge clk); #1;
        access(1'b1, 1'b0, 1'b0, 6'h30);
        check("R7", "cleared before reset", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        reg_re = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "halt dropped by reset", {31'b0, halt_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 1'b0, 1'b0, 6'h30);
        check("R1", "flag restored by reset", reg_rdata, 32'h1);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule